// File: doc/BRIEF.md
# External Bus Release Arbiter

This block decides when the on-chip bus masters (the processor and the data transfer controller) hand the external bus to an outside master. The outside master asks for the bus on an active-low request pin. The arbiter floats the address, data and strobe pins and then acknowledges. When the request is withdrawn, it drops the acknowledge, waits one clock, re-drives the pins and tells the internal masters with a one-clock pulse that the bus is back.

A request counts only when it is enabled twice: by a release-enable control bit and by the input-enable bit of the request pin. The hand-over waits until no external bus cycle is running. It also waits while the transfer controller is in a phase that cannot be interrupted: reading its transfer information, making its first data transfer, writing its information back, or running a chain of consecutive transfers.

The arbiter also answers a sleep request that would stop every module clock. While the bus is owned, clock-stop is granted one clock after the request. While the bus is released, entry is held off until the bus has been recovered. In clock-stop, new release requests are ignored.

Top module: `ext_bus_yield_arb`

## Requirements
- R1: A release starts only when `ext_req_n` is 0 and both `yield_en` and `pin_in_en` are 1; with either enable at 0 the pins stay driven (`pins_float` = 0) however long the request is held.
- R2: `ext_req_n` passes through two synchronizer flops. With no blocking condition, a request driven low before a clock edge raises `pins_float` at the third clock edge and not before.
- R3: While `cyc_active` is 1 the bus is not handed over. Once it falls with a qualified request pending, `pins_float` rises at the next clock edge.
- R4: While any of `xc_info_rd`, `xc_first_xfer` or `xc_info_wb` is 1 the bus is not handed over. Once the flag clears, the hand-over follows at the next clock edge.
- R5: While `xc_chain` is 1 (consecutive transfers in progress) the bus is not handed over. Release follows at the clock edge after the chain ends.
- R6: `grant_n` falls one clock edge after `pins_float` rises, and is 0 only while `pins_float` is 1.
- R7: The third clock edge after `ext_req_n` returns high sets `grant_n` to 1 while the pins still float. One edge later `pins_float` drops to 0 and `bus_back` is 1 for exactly one clock.
- R8: While the bus is owned, `clk_stop` rises one clock edge after `sleep_req` rises and falls one clock edge after `sleep_req` falls. A sleep request takes priority over a release request arriving in the same cycle.
- R9: While `clk_stop` is 1, release requests are ignored. A request that is still held after `clk_stop` falls is honoured at the following clock edge.
- R10: If `sleep_req` is 1 while the bus is released, `clk_stop` stays 0 until recovery. It rises one clock edge after the edge that re-drives the pins.
- R11: `rst_n` at 0 immediately, without waiting for a clock, forces `grant_n` = 1, `pins_float` = 0, `bus_back` = 0 and `clk_stop` = 0, whatever state the arbiter was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| yield_en | input | 1 | Release-enable control bit |
| pin_in_en | input | 1 | Input-enable bit of the request pin |
| cyc_active | input | 1 | An external bus cycle is in progress |
| xc_info_rd | input | 1 | Transfer controller is reading transfer information |
| xc_first_xfer | input | 1 | Transfer controller is in its first data transfer |
| xc_info_wb | input | 1 | Transfer controller is writing transfer information back |
| xc_chain | input | 1 | Transfer controller is running consecutive transfers |
| sleep_req | input | 1 | Request to enter all-module clock-stop sleep |
| grant_n | output | 1 | Active-low acknowledge to the outside master |
| pins_float | output | 1 | Place address, data and strobe pins in high impedance |
| bus_back | output | 1 | One-clock pulse: bus recovered by the internal masters |
| clk_stop | output | 1 | Clock-stop mode granted |

## Verification
The assertions assume that the sequencer's busy flag and the transfer controller's phase flags are synchronous to `clk`. They also assume that each flag stays stable until a clock edge has seen it. The bench therefore changes these flags, the enables and `sleep_req` only on falling clock edges. Only `ext_req_n` and `rst_n` are treated as truly asynchronous. The bench still moves them on falling edges, so that the expected latencies through the synchronizer are exact. Reset is pulsed in the floating, granted and clock-stop states, and the outputs are checked before any clock edge follows.

// File: rtl/ext_bus_yield_arb.sv
module ext_bus_yield_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req_n,
  input  logic yield_en,
  input  logic pin_in_en,
  input  logic cyc_active,
  input  logic xc_info_rd,
  input  logic xc_first_xfer,
  input  logic xc_info_wb,
  input  logic xc_chain,
  input  logic sleep_req,
  output logic grant_n,
  output logic pins_float,
  output logic bus_back,
  output logic clk_stop
);

  typedef enum logic [1:0] {OWNED, FLOATING, GRANTED, RETURNING} arb_st_t;

  arb_st_t    st_q, st_d;
  logic [1:0] req_sync_q;
  logic       req_seen;
  logic       req_live;
  logic       hold_bus;
  logic       start_rel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_sync_q <= 2'b11;
    else        req_sync_q <= {req_sync_q[0], ext_req_n};

  assign req_seen  = ~req_sync_q[1];
  assign req_live  = req_seen & yield_en & pin_in_en & ~clk_stop;
  assign hold_bus  = cyc_active | xc_info_rd | xc_first_xfer | xc_info_wb | xc_chain;
  assign start_rel = (st_q == OWNED) & req_live & ~hold_bus & ~sleep_req;

  always_comb begin
    st_d = st_q;
    case (st_q)
      OWNED:     if (start_rel) st_d = FLOATING;
      FLOATING:  st_d = GRANTED;
      GRANTED:   if (!req_seen) st_d = RETURNING;
      RETURNING: st_d = OWNED;
      default:   st_d = OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q     <= OWNED;
      bus_back <= 1'b0;
      clk_stop <= 1'b0;
    end else begin
      st_q     <= st_d;
      bus_back <= (st_q == RETURNING);
      clk_stop <= sleep_req & (st_q == OWNED);
    end

  assign pins_float = (st_q != OWNED);
  assign grant_n    = (st_q != GRANTED);

  // R3
  no_yield_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_float && cyc_active) |=> !pins_float);

  // R4
  no_yield_in_xc_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_float && (xc_info_rd || xc_first_xfer || xc_info_wb)) |=> !pins_float);

  // R5
  no_yield_in_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_float && xc_chain) |=> !pins_float);

  // R6
  grant_after_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_float) |=> (pins_float && !grant_n));

  // R6
  grant_inside_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_n) |-> $past(pins_float));

  // R7
  ack_drop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_n) |-> pins_float);

  // R7
  back_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_back |-> (!pins_float && $past(pins_float) && $past(grant_n)));

  // R7
  back_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_back |=> !bus_back);

  // R9
  stop_blocks_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |=> !pins_float);

  // R10
  stop_never_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> (!pins_float && grant_n));

endmodule

// File: tb/tb_ext_bus_yield_arb.sv
`timescale 1ns/1ps
module tb_ext_bus_yield_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_req_n = 1'b1;
  logic yield_en = 1'b0, pin_in_en = 1'b0, cyc_active = 1'b0;
  logic [3:0] xc = 4'b0;
  logic sleep_req = 1'b0;
  logic grant_n, pins_float, bus_back, clk_stop;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  ext_bus_yield_arb dut (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n),
    .yield_en(yield_en), .pin_in_en(pin_in_en), .cyc_active(cyc_active),
    .xc_info_rd(xc[0]), .xc_first_xfer(xc[1]), .xc_info_wb(xc[2]), .xc_chain(xc[3]),
    .sleep_req(sleep_req), .grant_n(grant_n), .pins_float(pins_float),
    .bus_back(bus_back), .clk_stop(clk_stop));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic outs(input string req, input logic g, input logic f, input logic b, input logic s);
    chk(req, "grant_n", grant_n, g);
    chk(req, "pins_float", pins_float, f);
    chk(req, "bus_back", bus_back, b);
    chk(req, "clk_stop", clk_stop, s);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_req_n = 1'b1; sleep_req = 1'b0; cyc_active = 1'b0; xc = '0;
    tick(2); rst_n = 1'b1; tick(1);
  endtask

  // request already synchronized and unblocked: float now, grant next
  task automatic grant_now(input string req);
    tick(1); chk(req, "float rise", pins_float, 1'b1); chk(req, "no grant yet", grant_n, 1'b1);
    tick(1); chk("R6", "grant after float", grant_n, 1'b0);
  endtask

  task automatic give_back(input string req);
    ext_req_n = 1'b1;
    tick(2); chk(req, "grant held", grant_n, 1'b0);
    tick(1); outs("R7", 1'b1, 1'b1, 1'b0, 1'b0);
    tick(1); chk("R7", "redrive", pins_float, 1'b0); chk("R7", "back pulse", bus_back, 1'b1);
    tick(1); chk("R7", "pulse ends", bus_back, 1'b0);
  endtask

  task automatic t_reset_state();
    do_reset();
    outs("R11", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_qualify();
    yield_en = 1'b0; pin_in_en = 1'b1; ext_req_n = 1'b0;
    tick(6); chk("R1", "yield_en off", pins_float, 1'b0);
    yield_en = 1'b1; pin_in_en = 1'b0;
    tick(6); chk("R1", "pin_in_en off", pins_float, 1'b0);
    ext_req_n = 1'b1; pin_in_en = 1'b1; tick(3);
    ext_req_n = 1'b0;
    tick(2); chk("R2", "no float after 2 edges", pins_float, 1'b0);
    tick(1); chk("R2", "float at edge 3", pins_float, 1'b1); chk("R6", "grant not yet", grant_n, 1'b1);
    tick(1); chk("R6", "grant edge 4", grant_n, 1'b0);
    give_back("R7");
  endtask

  task automatic t_bus_cycle();
    cyc_active = 1'b1; ext_req_n = 1'b0;
    tick(8); chk("R3", "held in cycle", pins_float, 1'b0);
    cyc_active = 1'b0;
    grant_now("R3");
    give_back("R7");
  endtask

  task automatic t_xc_phase(input int k);
    string r;
    r = (k == 3) ? "R5" : "R4";
    xc = 4'b0; xc[k] = 1'b1; ext_req_n = 1'b0;
    tick(8); chk(r, "held in phase", pins_float, 1'b0);
    xc = 4'b0;
    grant_now(r);
    give_back("R7");
  endtask

  task automatic t_sleep_owned();
    sleep_req = 1'b1;
    tick(1); chk("R8", "stop entry", clk_stop, 1'b1);
    ext_req_n = 1'b0;
    tick(6); chk("R9", "ignored in stop", pins_float, 1'b0);
    sleep_req = 1'b0;
    tick(1); chk("R8", "stop exit", clk_stop, 1'b0); chk("R9", "not same edge", pins_float, 1'b0);
    grant_now("R9");
    give_back("R7");
    // sleep and request arriving together: sleep wins
    sleep_req = 1'b1; ext_req_n = 1'b0;
    tick(4); chk("R8", "sleep priority", pins_float, 1'b0); chk("R8", "stop on", clk_stop, 1'b1);
    ext_req_n = 1'b1; tick(2); sleep_req = 1'b0; tick(1);
    chk("R8", "stop off", clk_stop, 1'b0);
  endtask

  task automatic t_deferred();
    ext_req_n = 1'b0; tick(2);
    grant_now("R2");
    sleep_req = 1'b1;
    tick(4); chk("R10", "deferred while released", clk_stop, 1'b0);
    ext_req_n = 1'b1;
    tick(3); chk("R10", "still deferred at ack drop", clk_stop, 1'b0);
    tick(1); chk("R10", "recovered", bus_back, 1'b1); chk("R10", "not yet at recovery", clk_stop, 1'b0);
    tick(1); chk("R10", "entry after recovery", clk_stop, 1'b1);
    sleep_req = 1'b0; tick(1);
    chk("R8", "exit", clk_stop, 1'b0);
  endtask

  task automatic t_reset_midway(input int k);
    ext_req_n = 1'b0;
    tick(k);
    #1 rst_n = 1'b0;
    #1 outs("R11", 1'b1, 1'b0, 1'b0, 1'b0);
    ext_req_n = 1'b1; tick(1); rst_n = 1'b1; tick(1);
    outs("R11", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset_in_stop();
    sleep_req = 1'b1; tick(2);
    chk("R8", "stop on", clk_stop, 1'b1);
    #1 rst_n = 1'b0;
    #1 chk("R11", "stop cleared", clk_stop, 1'b0);
    sleep_req = 1'b0; tick(1); rst_n = 1'b1; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(1);
    t_reset_state();
    yield_en = 1'b1; pin_in_en = 1'b1;
    t_qualify();
    t_bus_cycle();
    for (int k = 0; k < 4; k++) t_xc_phase(k);
    t_sleep_owned();
    t_deferred();
    t_reset_midway(3);
    t_reset_midway(5);
    t_reset_midway(8);
    t_reset_in_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule